// File: doc/BRIEF.md
# Ratio-Clocked Two-Entry Stream FIFO

This block passes data words from a producer that runs on a slow clock to a consumer that runs on a fast clock. The slow clock is an integer division of the fast clock, so both come from one oscillator and their rising edges line up. The FIFO therefore needs no metastability synchronizers. It relies on a strobe from the clock divider that marks a fast cycle in which the slow-domain state is stable.

The producer offers a word with `in_valid`. The word is taken at a slow rising edge unless `in_full` is high. The consumer sees the oldest stored word on `out_data` whenever `out_empty` is low, and takes it with `out_take` at a fast rising edge. Each side learns about the other side's progress only at fast edges that close a strobe cycle. As a result, a written word becomes visible, and a freed slot becomes writable, one strobe later.

The strobe `slow_tick` must be high for exactly the fast cycle that ends at the last fast rising edge before each slow rising edge. The division ratio must be 2 or more.

Top module: `ratio_clk_fifo`

## Requirements
- R1: When both resets have been held long enough to span a slow rising edge, the block comes out of reset with `out_empty` high and `in_full` low.
- R2: Words leave in the order they were accepted. Whenever `out_empty` is low, `out_data` shows the oldest word not yet taken (first-word-fall-through).
- R3: A word accepted at a slow rising edge makes `out_empty` fall only after the next fast rising edge at which `slow_tick` is high, and never earlier.
- R4: `in_full` is high exactly when the number of accepted words minus the number of takes recorded at the latest `slow_tick` edge equals 2, the storage depth.
- R5: A take frees its slot for the producer only from the next fast rising edge at which `slow_tick` is high.
- R6: An offer made while `in_full` is high is dropped, and no stored word or position changes.
- R7: A take requested while `out_empty` is high has no effect.
- R8: While `out_empty` is low and no take happens, `out_data` holds its value from one fast cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; the consumer domain |
| rst_fast | input | 1 | Synchronous active-high reset, fast domain |
| clk_slow | input | 1 | Divided clock; the producer domain |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| slow_tick | input | 1 | Divider strobe; high in the fast cycle ending just before a slow rising edge |
| in_valid | input | 1 | Producer offers `in_data` at the slow edge |
| in_data | input | DATA_W | Word offered by the producer |
| in_full | output | 1 | Both entries are held or not yet known to be freed |
| out_take | input | 1 | Consumer removes the presented word at the fast edge |
| out_data | output | DATA_W | Oldest stored word |
| out_empty | output | 1 | No word is visible to the consumer |

## Verification
The in-RTL properties check, on every cycle, that neither side's view of occupancy goes beyond two entries. They also check that blocked offers and blocked takes leave the pointers unchanged, that the copied write position moves only on strobe edges, and that a presented word stays steady until it is taken. The exact one-strobe lag of visibility and of slot release, word ordering under mixed traffic, and the dropping of words offered against a full FIFO can only be shown by the bench's scenarios. These include fill-only, drain-only, saturated, random and mid-run reset traffic.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    localparam int unsigned DEPTH  = 2;
    localparam int unsigned SLOT_W = $clog2(DEPTH);
    localparam int unsigned PTR_W  = SLOT_W + 1;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [SLOT_W-1:0] slot_t;

    // Fast-domain view: own read position plus the two cross-domain copies.
    typedef struct packed {
        ptr_t rd;
        ptr_t wr_seen;
        ptr_t rd_snap;
    } rd_state_t;

    function automatic ptr_t ptr_next(ptr_t p);
        return p + ptr_t'(1);
    endfunction

    function automatic ptr_t ptr_gap(ptr_t ahead, ptr_t behind);
        return ahead - behind;
    endfunction

    function automatic slot_t ptr_slot(ptr_t p);
        return p[SLOT_W-1:0];
    endfunction

endpackage

// File: rtl/rcf_wr_side.sv
module rcf_wr_side
    import rcf_pkg::*;
(
    input  logic  clk_slow,
    input  logic  rst_slow,
    input  logic  in_valid,
    input  ptr_t  rd_snap,
    output logic  in_full,
    output logic  wr_en,
    output slot_t wr_slot,
    output ptr_t  wr_ptr
);

    ptr_t wr_q;

    assign in_full = (ptr_gap(wr_q, rd_snap) == ptr_t'(DEPTH));
    assign wr_en   = in_valid && !in_full;
    assign wr_slot = ptr_slot(wr_q);
    assign wr_ptr  = wr_q;

    always_ff @(posedge clk_slow) begin
        if (rst_slow) begin
            wr_q <= '0;
        end else if (wr_en) begin
            wr_q <= ptr_next(wr_q);
        end
    end

    // R4: the producer never runs more than DEPTH entries ahead of the copied read position
    a_r4_slow_bound: assert property (@(posedge clk_slow) disable iff (rst_slow)
        ptr_gap(wr_q, rd_snap) <= ptr_t'(DEPTH));

    // R6: an offer against a full FIFO leaves the write position alone
    a_r6_full_blocks: assert property (@(posedge clk_slow) disable iff (rst_slow)
        (in_full && in_valid) |=> $stable(wr_q));

endmodule

// File: rtl/rcf_store.sv
module rcf_store
    import rcf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_slow,
    input  logic              wr_en,
    input  slot_t             wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  slot_t             rd_slot,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0][DATA_W-1:0] slot_view;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk_slow) begin
            if (wr_en && (wr_slot == SLOT_W'(i))) begin
                word_q <= wr_data;
            end
        end

        assign slot_view[i] = word_q;
    end

    assign rd_data = slot_view[rd_slot];

endmodule

// File: rtl/rcf_rd_side.sv
module rcf_rd_side
    import rcf_pkg::*;
(
    input  logic  clk_fast,
    input  logic  rst_fast,
    input  logic  slow_tick,
    input  logic  out_take,
    input  ptr_t  wr_ptr,
    output logic  out_empty,
    output slot_t rd_slot,
    output ptr_t  rd_snap
);

    rd_state_t st_q, st_d;
    logic      take_ok;
    ptr_t      rd_nxt;

    assign out_empty = (st_q.rd == st_q.wr_seen);
    assign take_ok   = out_take && !out_empty;
    assign rd_nxt    = take_ok ? ptr_next(st_q.rd) : st_q.rd;
    assign rd_slot   = ptr_slot(st_q.rd);
    assign rd_snap   = st_q.rd_snap;

    always_comb begin
        st_d    = st_q;
        st_d.rd = rd_nxt;
        // On the strobe edge the slow state is quiet: copy it in and publish ours.
        if (slow_tick) begin
            st_d.wr_seen = wr_ptr;
            st_d.rd_snap = rd_nxt;
        end
    end

    always_ff @(posedge clk_fast) begin
        if (rst_fast) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the copied write position moves only on strobe edges
    a_r3_seen_on_tick: assert property (@(posedge clk_fast) disable iff (rst_fast)
        !slow_tick |=> $stable(st_q.wr_seen));

    // R2: the consumer never sees more than DEPTH entries outstanding
    a_r2_fast_bound: assert property (@(posedge clk_fast) disable iff (rst_fast)
        ptr_gap(st_q.wr_seen, st_q.rd) <= ptr_t'(DEPTH));

    // R7: a take on an empty FIFO does not move the read position
    a_r7_empty_blocks: assert property (@(posedge clk_fast) disable iff (rst_fast)
        (out_empty && out_take) |=> $stable(st_q.rd));

endmodule

// File: rtl/ratio_clk_fifo.sv
module ratio_clk_fifo
    import rcf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_fast,
    input  logic              rst_fast,
    input  logic              clk_slow,
    input  logic              rst_slow,
    input  logic              slow_tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_full,
    input  logic              out_take,
    output logic [DATA_W-1:0] out_data,
    output logic              out_empty
);

    logic  wr_en;
    slot_t wr_slot;
    slot_t rd_slot;
    ptr_t  wr_ptr;
    ptr_t  rd_snap;

    rcf_wr_side u_wr (
        .clk_slow (clk_slow),
        .rst_slow (rst_slow),
        .in_valid (in_valid),
        .rd_snap  (rd_snap),
        .in_full  (in_full),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_ptr   (wr_ptr)
    );

    rcf_store #(.DATA_W(DATA_W)) u_store (
        .clk_slow (clk_slow),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_data  (in_data),
        .rd_slot  (rd_slot),
        .rd_data  (out_data)
    );

    rcf_rd_side u_rd (
        .clk_fast  (clk_fast),
        .rst_fast  (rst_fast),
        .slow_tick (slow_tick),
        .out_take  (out_take),
        .wr_ptr    (wr_ptr),
        .out_empty (out_empty),
        .rd_slot   (rd_slot),
        .rd_snap   (rd_snap)
    );

    // R8: the presented word is steady until it is taken
    a_r8_data_stable: assert property (@(posedge clk_fast) disable iff (rst_fast || rst_slow)
        (!out_empty && !out_take) |=> $stable(out_data));

endmodule

// File: tb/ratio_clk_fifo_tb_top.sv
module ratio_clk_fifo_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW   = 8;
    localparam int DIV  = 3;
    localparam int HALF = (DIV + 1) / 2;

    logic          clk_f = 1'b0;
    logic          clk_s = 1'b0;
    logic          rst   = 1'b1;
    logic          tick  = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data  = '0;
    logic          out_take = 1'b0;
    logic          in_full;
    logic [DW-1:0] out_data;
    logic          out_empty;

    ratio_clk_fifo #(.DATA_W(DW)) dut_i (
        .clk_fast  (clk_f),
        .rst_fast  (rst),
        .clk_slow  (clk_s),
        .rst_slow  (rst),
        .slow_tick (tick),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_full   (in_full),
        .out_take  (out_take),
        .out_data  (out_data),
        .out_empty (out_empty)
    );

    // Behavioural reference: word queue plus counts of accepted words and takes.
    logic [DW-1:0] q[$];
    int wcount = 0, rcount = 0, visible = 0, rseen = 0;
    int ph = 0;
    int vectors = 0, miscompares = 0;
    logic [DW-1:0] data_ctr = '0;
    bit done = 0;

    // One fast cycle: rising edge with model update, falling edge with comparison.
    task automatic cycle();
        bit full_m, empty_m;
        #2.5;
        clk_f = 1'b1;
        if (ph == 0) clk_s = 1'b1;
        else if (ph == HALF) clk_s = 1'b0;
        if (rst) begin
            q.delete();
            wcount = 0; rcount = 0; visible = 0; rseen = 0;
        end else begin
            full_m  = ((wcount - rseen) == 2);
            empty_m = (rcount == visible);
            if (ph == 0 && in_valid && !full_m) begin
                q.push_back(in_data);
                wcount++;
            end
            if (out_take && !empty_m) begin
                void'(q.pop_front());
                rcount++;
            end
            if (tick) begin
                visible = wcount;
                rseen   = rcount;
            end
        end
        #2.5;
        clk_f = 1'b0;
        if (!rst) begin
            vectors++;
            if (in_full !== ((wcount - rseen) == 2)) begin
                miscompares++;
                $display("FAIL R1 R4 R5 R6 in_full: actual %b expected %b at %0t",
                         in_full, ((wcount - rseen) == 2), $time);
            end
            if (out_empty !== (rcount == visible)) begin
                miscompares++;
                $display("FAIL R1 R3 R7 out_empty: actual %b expected %b at %0t",
                         out_empty, (rcount == visible), $time);
            end
            if (rcount != visible && out_data !== q[0]) begin
                miscompares++;
                $display("FAIL R2 R8 out_data: actual %0h expected %0h at %0t",
                         out_data, q[0], $time);
            end
        end
        ph   = (ph + 1) % DIV;
        tick = (ph == DIV - 1);
    endtask

    task automatic run(int n, int p_enq, int p_deq);
        for (int i = 0; i < n; i++) begin
            in_valid = (($urandom % 100) < p_enq);
            in_data  = data_ctr;
            data_ctr = data_ctr + 1'b1;
            out_take = (($urandom % 100) < p_deq);
            cycle();
        end
    endtask

    initial begin
        rst = 1'b1;
        run(4 * DIV, 0, 0);
        rst = 1'b0;
        run(10, 0, 0);            // R1: idle after reset
        run(1, 100, 0);           // single offer
        run(4 * DIV, 0, 0);       // R3: visibility lag
        run(4 * DIV, 0, 100);     // drain it
        run(8 * DIV, 100, 0);     // R4 R6: fill and push against full
        run(8 * DIV, 0, 100);     // R5 R7: drain and take while empty
        run(300, 50, 50);         // R2 R8: mixed traffic
        run(200, 100, 100);       // saturated flow
        run(100, 100, 20);        // slow consumer
        rst = 1'b1;
        run(4 * DIV, 100, 100);   // mid-run reset
        rst = 1'b0;
        run(6, 0, 0);             // R1 again
        run(300, 60, 40);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R1: actual still running expected finished at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule